// File: doc/BRIEF.md
# Gated Prescaled Period Timer

This block is a 16-bit up-counter that measures time against a programmable period. Each prescaled tick moves the counter up by one. When a tick arrives while the counter equals the period value, the counter returns to zero and a sticky event flag is raised. An interrupt request follows that flag whenever the interrupt enable is set. Three count sources are available: every cycle of the system clock, system clock cycles while an external gate pin is high, and rising edges of an external clock pin. The external clock can be taken through a two-flop synchronizer or through a single capture stage.

Software reaches three registers over a small word-wide bus: control, counter and period. A ratio field selects the prescaler, which divides by 1, 8, 64 or 256. Two low-power request pins, idle and sleep, can freeze counting. Whether they do depends on the control settings.

Top module: `pst_timer`

## Requirements
- R1: While reset is asserted, and after it is released, the control, counter, period and flag registers are all zero and `irq` is 0.
- R2: Bus address 0 selects control, 1 selects the counter and 2 selects the period. Address 3 reads as zero. A control read returns bit0 run, bit1 external source, bit2 synchronize, bit3 gate enable, bit4 idle halt, bits6:5 prescale code, bit7 interrupt enable and bit8 event flag, with all higher bits zero. A write takes effect at the clock edge on which `bus_we` is high.
- R3: With run=1 and the internal source selected, the counter rises by one on each prescaled tick. On a tick where the counter equals the period, the counter becomes 0 and the flag is set.
- R4: Prescale code 00 gives one tick per count event, 01 one tick per 8, 10 one tick per 64 and 11 one tick per 256. The first tick comes after a full ratio of events from a cleared prescaler.
- R5: The prescaler is cleared by a counter write, by run being 0, and by reset. A counter write loads the written value and takes priority over a tick in the same cycle. With run=0 the counter holds.
- R6: Writing the control register never changes the counter value.
- R7: With gate enable=1 and the internal source selected, the counter advances on each system cycle in which the gate pin, delayed through two synchronizer flops, is high. When the external source is selected, gate enable has no effect.
- R8: With the external source selected, each rising edge of `tck_in` counts once. With synchronize=1 the edge is counted on the third clock edge after the pin rises. With synchronize=0 it is counted on the second.
- R9: While `idle_req` is high and idle halt=1, the counter and prescaler hold. With idle halt=0, counting goes on through idle. Counting resumes from the held value.
- R10: While `sleep_req` is high, the timer counts only when run=1, the external source is selected and synchronize=0. In every other setting it holds.
- R11: A period of 0 holds the counter at 0 and sets the flag on every prescaled tick.
- R12: The flag stays set until a control write with bit8=0 clears it. Writing bit8=1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R13: `irq` is high exactly when the flag and the interrupt enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| tck_in | input | 1 | External clock or gate pin |
| idle_req | input | 1 | Idle-mode request |
| sleep_req | input | 1 | Sleep-mode request |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- a matching tick returns the counter to zero and sets the flag;
- a clearing write drops the flag unless a match coincides;
- a counter write loads its value and empties the prescaler;
- control writes leave the counter alone;
- the counter holds while stopped, in a halting idle, or in a sleep that does not allow counting.

Only the bench scenarios can show:
- the tick spacing for each prescale ratio;
- the two-stage gate delay and the exact edge latency of the two external paths;
- counting that goes on through idle or sleep;
- a prescaler restart that shifts the next tick by a full ratio.

// File: rtl/pst_pkg.sv
package pst_pkg;

  // bus address width and register map
  localparam int unsigned PST_AW = 2;
  localparam logic [PST_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [PST_AW-1:0] ADDR_CNT  = 2'd1;
  localparam logic [PST_AW-1:0] ADDR_PER  = 2'd2;

  // prescale codes
  typedef enum logic [1:0] {
    SCL_1   = 2'b00,
    SCL_8   = 2'b01,
    SCL_64  = 2'b10,
    SCL_256 = 2'b11
  } scale_e;

  // control fields, LSB = run
  typedef struct packed {
    logic   irq_en;     // bit7
    scale_e scale;      // bits6:5
    logic   idle_halt;  // bit4
    logic   gate_en;    // bit3
    logic   sync_ext;   // bit2
    logic   src_ext;    // bit1
    logic   run;        // bit0
  } ctrl_t;

  localparam int unsigned CTRL_W   = $bits(ctrl_t);
  localparam int unsigned FLAG_BIT = CTRL_W;

endpackage

// File: rtl/pst_regs.sv
module pst_regs
  import pst_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PST_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              match,
  output ctrl_t             ctrl,
  output logic              flag,
  output logic [DW-1:0]     period,
  output logic              cnt_wr
);

  logic  ctrl_wr;
  logic  per_wr;
  ctrl_t ctrl_d;
  logic  flag_d;
  logic  flag_en;

  // decode
  always_comb begin
    ctrl_wr = we && (addr == ADDR_CTRL);
    per_wr  = we && (addr == ADDR_PER);
    cnt_wr  = we && (addr == ADDR_CNT);
  end

  // next state
  always_comb begin
    ctrl_d  = ctrl_t'(wdata[CTRL_W-1:0]);
    flag_en = match || (ctrl_wr && !wdata[FLAG_BIT]);
    flag_d  = match;  // set wins over clear
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= '0;
    end else if (per_wr) begin
      period <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flag_en) begin
      flag <= flag_d;
    end
  end

endmodule

// File: rtl/pst_tick_src.sv
module pst_tick_src #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tck_in,
  input  logic src_ext,
  input  logic sync_ext,
  input  logic gate_en,
  output logic raw_tick
);

  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;
  logic             gate_lvl;
  logic             edge_sync;
  logic             edge_async;

  // capture chain: stage 0 samples the pin, each later stage delays by one
  always_comb begin
    chain_d[0] = tck_in;
  end

  for (genvar g = 1; g < CHAIN; g++) begin : g_chain
    always_comb chain_d[g] = chain_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  // source selection
  always_comb begin
    gate_lvl   = chain_q[SYNC_STAGES-1];
    edge_sync  = chain_q[SYNC_STAGES-1] && !chain_q[SYNC_STAGES];
    edge_async = chain_q[0] && !chain_q[1];
    if (src_ext) begin
      raw_tick = sync_ext ? edge_sync : edge_async;
    end else if (gate_en) begin
      raw_tick = gate_lvl;
    end else begin
      raw_tick = 1'b1;
    end
  end

endmodule

// File: rtl/pst_prescale.sv
module pst_prescale
  import pst_pkg::*;
#(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  scale_e        scale,
  output logic          tick,
  output logic [PW-1:0] pre_cnt
);

  localparam logic [PW-1:0] TERM_1   = PW'(0);
  localparam logic [PW-1:0] TERM_8   = PW'(8 - 1);
  localparam logic [PW-1:0] TERM_64  = PW'(64 - 1);
  localparam logic [PW-1:0] TERM_256 = PW'(256 - 1);

  logic [PW-1:0] term;
  logic          at_term;
  logic [PW-1:0] pre_d;
  logic          pre_en;

  always_comb begin
    unique case (scale)
      SCL_1:   term = TERM_1;
      SCL_8:   term = TERM_8;
      SCL_64:  term = TERM_64;
      default: term = TERM_256;
    endcase
  end

  // next state
  always_comb begin
    at_term = (pre_cnt == term);
    tick    = adv && at_term;
    pre_en  = clr || adv;
    if (clr || at_term) begin
      pre_d = '0;
    end else begin
      pre_d = pre_cnt + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (pre_en) begin
      pre_cnt <= pre_d;
    end
  end

endmodule

// File: rtl/pst_count.sv
module pst_count #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          tick,
  input  logic [DW-1:0] period,
  output logic [DW-1:0] count,
  output logic          match
);

  logic [DW-1:0] count_d;
  logic          count_en;

  // next state: a load beats a tick
  always_comb begin
    match    = tick && !load && (count == period);
    count_en = load || tick;
    if (load) begin
      count_d = load_val;
    end else if (match) begin
      count_d = '0;
    end else begin
      count_d = count + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (count_en) begin
      count <= count_d;
    end
  end

endmodule

// File: rtl/pst_timer.sv
module pst_timer
  import pst_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned PW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [PST_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              tck_in,
  input  logic              idle_req,
  input  logic              sleep_req,
  output logic              irq
);

  localparam int unsigned PAD_W = DW - CTRL_W - 1;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  ctrl_t         ctrl_q;
  logic          flag_q;
  logic [DW-1:0] period_q;
  logic [DW-1:0] count_q;
  logic          cnt_wr;
  logic          match;
  logic          raw_tick;
  logic          tick;
  logic [PW-1:0] pre_cnt;
  logic          sleep_ok;
  logic          count_en;
  logic          pre_clr;
  logic          run_s;
  logic          src_ext_s;
  logic          sync_s;
  logic          idle_halt_s;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  pst_regs #(.DW(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .match  (match),
    .ctrl   (ctrl_q),
    .flag   (flag_q),
    .period (period_q),
    .cnt_wr (cnt_wr)
  );

  pst_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tck_in   (tck_in),
    .src_ext  (ctrl_q.src_ext),
    .sync_ext (ctrl_q.sync_ext),
    .gate_en  (ctrl_q.gate_en),
    .raw_tick (raw_tick)
  );

  // counting enable: low-power pins and control settings
  always_comb begin
    run_s       = ctrl_q.run;
    src_ext_s   = ctrl_q.src_ext;
    sync_s      = ctrl_q.sync_ext;
    idle_halt_s = ctrl_q.idle_halt;
    sleep_ok    = src_ext_s && !sync_s;
    count_en    = run_s
                  && !(idle_req && idle_halt_s)
                  && !(sleep_req && !sleep_ok);
    pre_clr     = cnt_wr || !run_s;
  end

  pst_prescale #(.PW(PW)) u_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (pre_clr),
    .adv     (raw_tick && count_en),
    .scale   (ctrl_q.scale),
    .tick    (tick),
    .pre_cnt (pre_cnt)
  );

  pst_count #(.DW(DW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (cnt_wr),
    .load_val (bus_wdata),
    .tick     (tick),
    .period   (period_q),
    .count    (count_q),
    .match    (match)
  );

  // read mux
  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = {{PAD_W{1'b0}}, flag_q, ctrl_q};
      ADDR_CNT:  bus_rdata = count_q;
      ADDR_PER:  bus_rdata = period_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = flag_q && ctrl_q.irq_en;

endmodule

// File: rtl/pst_timer_chk.sv
module pst_timer_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          idle_req,
  input logic          sleep_req,
  input logic          run,
  input logic          src_ext,
  input logic          sync_ext,
  input logic          idle_halt,
  input logic          tick,
  input logic [DW-1:0] count,
  input logic [DW-1:0] period,
  input logic          flag,
  input logic [PW-1:0] pre_cnt
);

  logic ctrl_wr;
  logic cnt_wr;
  logic hit;

  always_comb begin
    ctrl_wr = bus_we && (bus_addr == 2'd0);
    cnt_wr  = bus_we && (bus_addr == 2'd1);
    hit     = tick && !cnt_wr && (count == period);
  end

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (count == '0));

  assert_flag_on_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[8] && !hit) |=> !flag);

  assert_ctrl_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !tick) |=> $stable(count));

  assert_load_clears_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (pre_cnt == '0) && (count == $past(bus_wdata)));

  assert_stopped_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && idle_halt && !cnt_wr) |=> $stable(count));

  assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !(src_ext && !sync_ext) && !cnt_wr) |=> $stable(count));

endmodule

bind pst_timer pst_timer_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .idle_req  (idle_req),
  .sleep_req (sleep_req),
  .run       (run_s),
  .src_ext   (src_ext_s),
  .sync_ext  (sync_s),
  .idle_halt (idle_halt_s),
  .tick      (tick),
  .count     (count_q),
  .period    (period_q),
  .flag      (flag_q),
  .pre_cnt   (pre_cnt)
);

// File: tb/pst_timer_bench.sv
`timescale 1ns/1ps
module pst_timer_bench;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_PER  = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        tck_in;
  logic        idle_req;
  logic        sleep_req;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  pst_timer u_pst_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tck_in    (tck_in),
    .idle_req  (idle_req),
    .sleep_req (sleep_req),
    .irq       (irq)
  );

  always #5 clk = ~clk;

  // bit8 = flag write (1 keeps), bit7 irq_en, 6:5 scale, 4 idle halt,
  // 3 gate, 2 sync, 1 ext source, 0 run
  function automatic logic [15:0] mk(input bit run, input bit src, input bit syn,
                                      input bit gate, input bit idh,
                                      input logic [1:0] sc, input bit ie,
                                      input bit fk);
    return {7'b0, fk, ie, sc, idh, gate, syn, src, run};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = A_CTRL;
    bus_wdata = '0;
    tck_in    = 1'b0;
    idle_req  = 1'b0;
    sleep_req = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      tck_in = 1'b1;
      step(3);
      tck_in = 1'b0;
      step(3);
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(A_CTRL, v); check("R1 ctrl", v, 16'h0000);
    rd(A_CNT, v);  check("R1 count", v, 16'h0000);
    rd(A_PER, v);  check("R1 period", v, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_map();
    logic [15:0] v;
    do_reset();
    wr(A_CNT, 16'd42);
    wr(A_PER, 16'h1234);
    wr(A_CTRL, mk(0, 1, 1, 1, 1, 2'b11, 1, 1));
    rd(A_CTRL, v); check("R2 ctrl readback", v, 16'h00FE);
    rd(A_PER, v);  check("R2 period readback", v, 16'h1234);
    rd(2'd3, v);   check("R2 unused address", v, 16'h0000);
    rd(A_CNT, v);  check("R6 count kept after ctrl write", v, 16'd42);
  endtask

  task automatic t_basic();
    logic [15:0] v;
    do_reset();
    wr(A_PER, 16'd5);
    wr(A_CTRL, mk(1, 0, 0, 0, 0, 2'b00, 0, 1));
    step(5);
    rd(A_CNT, v); check("R3 count reaches period", v, 16'd5);
    step(1);
    rd(A_CNT, v); check("R3 wrap to zero", v, 16'd0);
    rd(A_CTRL, v); check("R3 flag set on match", {15'b0, v[8]}, 16'd1);
    check("R13 irq off with enable 0", {15'b0, irq}, 16'd0);
    wr(A_CTRL, mk(1, 0, 0, 0, 0, 2'b00, 1, 1));
    check("R13 irq with flag and enable", {15'b0, irq}, 16'd1);
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 2'b00, 1, 1));
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 2'b00, 1, 0));
    rd(A_CTRL, v); check("R12 flag cleared by write 0", {15'b0, v[8]}, 16'd0);
    check("R13 irq drops with flag", {15'b0, irq}, 16'd0);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    int ratio;
    for (int s = 0; s < 4; s++) begin
      ratio = (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 64 : 256;
      do_reset();
      wr(A_PER, 16'hFFFF);
      wr(A_CTRL, mk(1, 0, 0, 0, 0, 2'(s), 0, 1));
      step(ratio - 1);
      rd(A_CNT, v); check($sformatf("R4 code %0d before first tick", s), v, 16'd0);
      step(1);
      rd(A_CNT, v); check($sformatf("R4 code %0d first tick", s), v, 16'd1);
      step(ratio);
      rd(A_CNT, v); check($sformatf("R4 code %0d second tick", s), v, 16'd2);
    end
  endtask

  task automatic t_preclear();
    logic [15:0] v;
    do_reset();
    wr(A_PER, 16'hFFFF);
    wr(A_CTRL, mk(1, 0, 0, 0, 0, 2'b01, 0, 1));
    step(5);
    wr(A_CNT, 16'd100);
    rd(A_CNT, v); check("R5 counter write loads", v, 16'd100);
    step(7);
    rd(A_CNT, v); check("R5 prescaler restarted by write", v, 16'd100);
    step(1);
    rd(A_CNT, v); check("R5 tick one ratio after write", v, 16'd101);
    step(3);
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 2'b01, 0, 1));
    step(4);
    rd(A_CNT, v); check("R5 stopped counter holds", v, 16'd101);
    wr(A_CTRL, mk(1, 0, 0, 0, 0, 2'b01, 0, 1));
    step(7);
    rd(A_CNT, v); check("R5 prescaler cleared by disable", v, 16'd101);
    step(1);
    rd(A_CNT, v); check("R5 tick after re-enable", v, 16'd102);
  endtask

  task automatic t_period0();
    logic [15:0] v;
    do_reset();
    wr(A_CTRL, mk(1, 0, 0, 0, 0, 2'b00, 0, 1));
    step(1);
    rd(A_CNT, v);  check("R11 counter held at zero", v, 16'd0);
    rd(A_CTRL, v); check("R11 flag on tick", {15'b0, v[8]}, 16'd1);
    wr(A_CTRL, mk(1, 0, 0, 0, 0, 2'b00, 0, 0));
    rd(A_CTRL, v); check("R12 match beats clear", {15'b0, v[8]}, 16'd1);
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 2'b00, 0, 1));
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 2'b00, 0, 0));
    rd(A_CTRL, v); check("R12 clear when idle", {15'b0, v[8]}, 16'd0);
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 2'b00, 0, 1));
    rd(A_CTRL, v); check("R12 writing 1 does not set", {15'b0, v[8]}, 16'd0);
    wr(A_CTRL, mk(1, 0, 0, 0, 0, 2'b00, 0, 1));
    step(1);
    rd(A_CTRL, v); check("R11 flag again on next tick", {15'b0, v[8]}, 16'd1);
    rd(A_CNT, v);  check("R11 counter still zero", v, 16'd0);
  endtask

  task automatic t_gate();
    logic [15:0] v;
    do_reset();
    wr(A_PER, 16'hFFFF);
    wr(A_CTRL, mk(1, 0, 0, 1, 0, 2'b00, 0, 1));
    step(5);
    rd(A_CNT, v); check("R7 gate low holds", v, 16'd0);
    tck_in = 1'b1;
    step(2);
    rd(A_CNT, v); check("R7 two-stage gate delay", v, 16'd0);
    step(8);
    tck_in = 1'b0;
    step(5);
    rd(A_CNT, v); check("R7 counts gated cycles", v, 16'd10);
  endtask

  task automatic t_ext();
    logic [15:0] v;
    do_reset();
    wr(A_PER, 16'hFFFF);
    wr(A_CTRL, mk(1, 1, 1, 1, 0, 2'b00, 0, 1));
    tck_in = 1'b1;
    step(2);
    rd(A_CNT, v); check("R8 sync edge not yet counted", v, 16'd0);
    step(1);
    rd(A_CNT, v); check("R8 sync edge on third clock", v, 16'd1);
    tck_in = 1'b0;
    step(3);
    pulses(5);
    step(4);
    rd(A_CNT, v); check("R7 R8 edges counted, gate ignored", v, 16'd6);
    do_reset();
    wr(A_PER, 16'hFFFF);
    wr(A_CTRL, mk(1, 1, 0, 0, 0, 2'b00, 0, 1));
    tck_in = 1'b1;
    step(1);
    rd(A_CNT, v); check("R8 async edge not yet counted", v, 16'd0);
    step(1);
    rd(A_CNT, v); check("R8 async edge on second clock", v, 16'd1);
    tck_in = 1'b0;
    step(3);
    pulses(5);
    step(4);
    rd(A_CNT, v); check("R8 async edges counted", v, 16'd6);
  endtask

  task automatic t_idle();
    logic [15:0] v;
    do_reset();
    wr(A_PER, 16'hFFFF);
    wr(A_CTRL, mk(1, 0, 0, 0, 1, 2'b00, 0, 1));
    step(4);
    idle_req = 1'b1;
    step(10);
    rd(A_CNT, v); check("R9 idle halt holds", v, 16'd4);
    idle_req = 1'b0;
    step(3);
    rd(A_CNT, v); check("R9 resumes from held value", v, 16'd7);
    wr(A_CTRL, mk(1, 0, 0, 0, 0, 2'b00, 0, 1));
    idle_req = 1'b1;
    step(5);
    rd(A_CNT, v); check("R9 counts through idle", v, 16'd13);
    idle_req = 1'b0;
  endtask

  task automatic t_sleep();
    logic [15:0] v;
    do_reset();
    wr(A_PER, 16'hFFFF);
    wr(A_CTRL, mk(1, 0, 0, 0, 0, 2'b00, 0, 1));
    sleep_req = 1'b1;
    step(5);
    rd(A_CNT, v); check("R10 internal source holds in sleep", v, 16'd0);
    wr(A_CTRL, mk(1, 1, 1, 0, 0, 2'b00, 0, 1));
    step(4);
    pulses(3);
    step(4);
    rd(A_CNT, v); check("R10 synced external holds in sleep", v, 16'd0);
    wr(A_CTRL, mk(1, 1, 0, 0, 0, 2'b00, 0, 1));
    step(4);
    pulses(3);
    step(4);
    rd(A_CNT, v); check("R10 async external counts in sleep", v, 16'd3);
    sleep_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_map();
    t_basic();
    t_prescale();
    t_preclear();
    t_period0();
    t_gate();
    t_ext();
    t_idle();
    t_sleep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule